// File: doc/BRIEF.md
# Interrupt-Capable Eight-Pin I/O Port

This block is one general-purpose I/O port of configurable width, eight pins by default. It sits on a simple register bus with single-cycle writes and a combinational read. Four stored per-pin registers together choose what each pin does: a value register, a direction register and two function-select registers. A fifth address takes write-one-to-clear strobes. Each pin works on its own as a plain input, a plain output, a pass-through for an alternate peripheral, a level-qualified interrupt source or a latched single-edge interrupt source.

Every pin input passes through a synchroniser clocked by the system clock before any internal logic sees it. In the two interrupt modes, the value register bit no longer drives the pin. It sets the polarity of the trigger instead. Each pin has its own interrupt request output, which goes to an external controller. A peripheral on the alternate side sees its input held at an idle level unless the pin has been handed over to it.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every pin is a plain input. The direction register reads all ones, both select registers and the value register read zero, every pin_oe bit is 0, every irq bit is 0 and alt_in equals its idle level (all ones by default).
- R2: A write with bus_wr high updates one register at the next clock edge. The address map is: 0 = value register, 1 = direction, 3 = select-A, 4 = select-B. Address 2 is the clear strobe and always reads 0. Registers 1, 3 and 4 read back what was written.
- R3: The mode of pin i comes from bit i of select-B, select-A and direction. Both selects 1: direction 1 gives edge interrupt and direction 0 gives level interrupt. Select-A 1 with select-B 0 gives alternate pass-through. Select-A 0 with select-B 1 gives plain input. Both selects 0: direction 1 gives plain input and direction 0 gives plain output.
- R4: In plain output mode the pin drives the value register bit with pin_oe at 1. In input and both interrupt modes pin_oe is 0.
- R5: In alternate mode pin_out and pin_oe follow alt_out and alt_oe. The value register has no effect on the pin.
- R6: In alternate mode alt_in carries the pin input after a two-flop synchroniser, so a change appears after two clock edges. In every other mode alt_in holds the idle level.
- R7: Reading address 0 returns the synchronised pin for pins in input, level or edge mode. For pins in output or alternate mode it returns the value register bit.
- R8: In level mode the value bit selects the active level (0 = low, 1 = high). irq rises only once the synchronised pin has matched that level for two consecutive clock cycles. A one-cycle match never raises it.
- R9: A level interrupt stays up while the level holds. It drops in the same cycle the synchronised pin leaves that level.
- R10: In edge mode the value bit selects the edge (0 = falling, 1 = rising) seen on the synchronised input. The request latches and stays high after the pin returns. The opposite edge is ignored.
- R11: Writing 1 to bit i at address 2 clears the latched edge request of pin i. Zero bits leave other pins' requests untouched.
- R12: If a selected edge and a clear for the same pin land in the same cycle, the request ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr (combinational) |
| pin_in | input | WIDTH | Raw pin inputs |
| pin_out | output | WIDTH | Pin output values |
| pin_oe | output | WIDTH | Pin output enables, 1 drives |
| alt_out | input | WIDTH | Alternate peripheral output values |
| alt_oe | input | WIDTH | Alternate peripheral output enables |
| alt_in | output | WIDTH | Synchronised pin inputs to the alternate peripheral |
| irq | output | WIDTH | Per-pin interrupt requests |

## Verification
The edge detector and the clear strobe can act on the same pin in one cycle. A rising edge is applied to an edge-mode pin, and after two clock edges the synchroniser presents it. The bench times the clear write so that it hits the very edge at which the detector fires. The request must read 1 at the following sample, and a separate clear afterwards must take it to 0. This shows the collision was resolved toward keeping the event.

// File: rtl/gpio_irq_port_pkg.sv
package gpio_irq_port_pkg;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_VALUE = 3'd0;
   localparam logic [ADDR_W-1:0] A_DIR   = 3'd1;
   localparam logic [ADDR_W-1:0] A_CLEAR = 3'd2;
   localparam logic [ADDR_W-1:0] A_SELA  = 3'd3;
   localparam logic [ADDR_W-1:0] A_SELB  = 3'd4;

   typedef enum logic [2:0] {
      PM_INPUT,
      PM_OUTPUT,
      PM_ALTFN,
      PM_LEVEL,
      PM_EDGE
   } pin_mode_e;

   function automatic pin_mode_e decode_mode(input logic dir, input logic sel_a,
                                             input logic sel_b);
      if (sel_b && sel_a) return dir ? PM_EDGE : PM_LEVEL;
      if (sel_a)          return PM_ALTFN;
      if (sel_b)          return PM_INPUT;
      return dir ? PM_INPUT : PM_OUTPUT;
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
   import gpio_irq_port_pkg::*;
#(
   parameter int QUAL_CYCLES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pin_mode_e mode,
   input  logic      pol,
   input  logic      pin_s,
   input  logic      clr,
   output logic      irq
);

   localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(QUAL_CYCLES);

   generate
      if (QUAL_CYCLES < 1) begin : g_bad_qual
         $error("gpio_irq_pin: QUAL_CYCLES must be at least 1");
      end
   endgenerate

   logic             pin_d;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             lvl_match;
   logic             lvl_irq;
   logic             edge_hit;

   assign lvl_match = (mode == PM_LEVEL) && (pin_s == pol);
   assign lvl_irq   = lvl_match && (cnt_q == CNT_TOP);
   assign edge_hit  = (mode == PM_EDGE) &&
                      (pol ? (pin_s && !pin_d) : (!pin_s && pin_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_d  <= 1'b0;
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         pin_d <= pin_s;
         if (!lvl_match)            cnt_q <= '0;
         else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
         if (edge_hit)  pend_q <= 1'b1;
         else if (clr)  pend_q <= 1'b0;
      end
   end

   assign irq = lvl_irq || pend_q;

   // R8
   lvl_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_irq |-> $past(lvl_match));

   // R10
   edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> pend_q);

   // R11
   edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !edge_hit) |=> !pend_q);

   // R10
   no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !edge_hit) |=> !pend_q);

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_port_pkg::*;
#(
   parameter int               WIDTH       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter int               QUAL_CYCLES = 2,
   parameter logic [WIDTH-1:0] ALT_IN_IDLE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   input  logic [WIDTH-1:0]  alt_out,
   input  logic [WIDTH-1:0]  alt_oe,
   output logic [WIDTH-1:0]  alt_in,
   output logic [WIDTH-1:0]  irq
);

   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("gpio_irq_port: WIDTH must lie in 1..32");
      end
   endgenerate

   logic [WIDTH-1:0] value_q, dir_q, sela_q, selb_q;
   logic [WIDTH-1:0] pin_s;
   logic [WIDTH-1:0] clr_vec;
   logic [WIDTH-1:0] value_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
         dir_q   <= '1;
         sela_q  <= '0;
         selb_q  <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_VALUE: value_q <= bus_wdata;
            A_DIR:   dir_q   <= bus_wdata;
            A_SELA:  sela_q  <= bus_wdata;
            A_SELB:  selb_q  <= bus_wdata;
            default: ;
         endcase
      end
   end

   assign clr_vec = (bus_wr && bus_addr == A_CLEAR) ? bus_wdata : '0;

   gpio_irq_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (pin_s)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pin_mode_e mode;
      logic      is_alt;
      assign mode   = decode_mode(dir_q[i], sela_q[i], selb_q[i]);
      assign is_alt = (mode == PM_ALTFN);

      assign pin_out[i]  = is_alt ? alt_out[i] : value_q[i];
      assign pin_oe[i]   = is_alt ? alt_oe[i] : (mode == PM_OUTPUT);
      assign alt_in[i]   = is_alt ? pin_s[i] : ALT_IN_IDLE[i];
      assign value_rd[i] = (is_alt || mode == PM_OUTPUT) ? value_q[i] : pin_s[i];

      gpio_irq_pin #(.QUAL_CYCLES(QUAL_CYCLES)) i_pin (
         .clk  (clk),
         .rst_n(rst_n),
         .mode (mode),
         .pol  (value_q[i]),
         .pin_s(pin_s[i]),
         .clr  (clr_vec[i]),
         .irq  (irq[i])
      );
   end

   always_comb begin
      case (bus_addr)
         A_VALUE: bus_rdata = value_rd;
         A_DIR:   bus_rdata = dir_q;
         A_SELA:  bus_rdata = sela_q;
         A_SELB:  bus_rdata = selb_q;
         default: bus_rdata = '0;
      endcase
   end

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DIR) |=> dir_q == $past(bus_wdata));

   // R2
   sela_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SELA) |=> sela_q == $past(bus_wdata));

endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out, pin_oe, alt_in, irq;
   logic [7:0] alt_out = 8'h00;
   logic [7:0] alt_oe = 8'h00;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_port i_gpio_irq_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe),
      .alt_in(alt_in), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      rd(3'd1, v); chk("R1 dir", v, 8'hFF);
      rd(3'd3, v); chk("R1 selA", v, 8'h00);
      rd(3'd4, v); chk("R1 selB", v, 8'h00);
      chk("R1 oe", pin_oe, 8'h00);
      chk("R1 irq", irq, 8'h00);
      chk("R1 alt_in idle", alt_in, 8'hFF);
   endtask

   task automatic t_regs;
      logic [7:0] v;
      wr(3'd3, 8'h3C); wr(3'd4, 8'hC3);
      rd(3'd3, v); chk("R2 selA readback", v, 8'h3C);
      rd(3'd4, v); chk("R2 selB readback", v, 8'hC3);
      rd(3'd2, v); chk("R2 clear reads 0", v, 8'h00);
      // R3: selA=0/selB=1 bits are plain inputs, never drive
      chk("R3 reserved is input", pin_oe & 8'hC3, 8'h00);
      wr(3'd3, 8'h00); wr(3'd4, 8'h00);
   endtask

   task automatic t_output;
      logic [7:0] v;
      wr(3'd0, 8'hA5); wr(3'd1, 8'h00);
      chk("R4 pin_out", pin_out, 8'hA5);
      chk("R4 pin_oe", pin_oe, 8'hFF);
      rd(3'd0, v); chk("R7 output reads value", v, 8'hA5);
      wr(3'd1, 8'hFF);
      chk("R4 input oe off", pin_oe, 8'h00);
   endtask

   task automatic t_input;
      logic [7:0] v;
      pin_in = 8'h5A;
      step(2);
      rd(3'd0, v); chk("R7 input reads pin", v, 8'h5A);
   endtask

   task automatic t_alt;
      logic [7:0] v;
      alt_out = 8'h3C; alt_oe = 8'hF0;
      wr(3'd0, 8'hFF); wr(3'd3, 8'hFF);
      chk("R5 alt pin_out", pin_out, 8'h3C);
      chk("R5 alt pin_oe", pin_oe, 8'hF0);
      wr(3'd0, 8'h00);
      chk("R5 value ignored", pin_out, 8'h3C);
      rd(3'd0, v); chk("R7 alt reads value", v, 8'h00);
      chk("R6 alt_in passes", alt_in, 8'h5A);
      pin_in = 8'h96;
      step(1); chk("R6 alt_in one edge", alt_in, 8'h5A);
      step(1); chk("R6 alt_in two edges", alt_in, 8'h96);
      wr(3'd3, 8'h00);
      chk("R6 alt_in idle", alt_in, 8'hFF);
   endtask

   task automatic t_level;
      pin_in = 8'hFD;
      wr(3'd0, 8'h02); wr(3'd4, 8'h03); wr(3'd3, 8'h03); wr(3'd1, 8'hFC);
      step(4); chk("R8 no match", irq, 8'h00);
      pin_in = 8'hFC;
      step(3); chk("R8 before qualify", irq[0], 1'b0);
      step(1); chk("R8 low level qualified", irq[0], 1'b1);
      step(3); chk("R9 held", irq[0], 1'b1);
      pin_in = 8'hFD;
      step(1); chk("R9 still synced low", irq[0], 1'b1);
      step(1); chk("R9 drop", irq[0], 1'b0);
      pin_in = 8'hFC;
      step(1);
      pin_in = 8'hFD;
      for (int k = 0; k < 5; k++) begin
         step(1); chk("R8 one-cycle pulse", irq[0], 1'b0);
      end
      pin_in = 8'hFE;
      step(3); chk("R8 high before qualify", irq[1:0], 2'b00);
      step(1); chk("R8 high level qualified", irq[1:0], 2'b11);
      pin_in = 8'hFF;
      step(3);
      wr(3'd4, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'hFF);
      chk("R3 back to input", irq, 8'h00);
   endtask

   task automatic t_edge;
      logic [7:0] v;
      wr(3'd0, 8'h08); wr(3'd4, 8'h0C); wr(3'd3, 8'h0C);
      step(3); chk("R10 idle", irq, 8'h00);
      pin_in = 8'hFB;
      step(2); chk("R10 fall not yet", irq[2], 1'b0);
      step(1); chk("R10 falling latched", irq[2], 1'b1);
      rd(3'd0, v); chk("R7 edge reads pin", v[3:2], 2'b10);
      pin_in = 8'hFF;
      step(4); chk("R10 latch holds", irq[2], 1'b1);
      pin_in = 8'hF7;
      step(4); chk("R10 opposite edge ignored", irq[3], 1'b0);
      pin_in = 8'hFF;
      step(3); chk("R10 rising latched", irq[3], 1'b1);
      wr(3'd2, 8'h04);
      chk("R11 cleared pin", irq[3:2], 2'b10);
      wr(3'd2, 8'h00);
      chk("R11 zero write no effect", irq[3], 1'b1);
      wr(3'd2, 8'h08);
      chk("R11 second clear", irq[3:2], 2'b00);
   endtask

   task automatic t_collide;
      pin_in = 8'hF7;
      step(4); chk("R12 setup", irq[3], 1'b0);
      pin_in = 8'hFF;
      step(2); chk("R12 before edge", irq[3], 1'b0);
      wr(3'd2, 8'h08);
      chk("R12 set wins", irq[3], 1'b1);
      wr(3'd2, 8'h08);
      chk("R11 clear after collision", irq[3], 1'b0);
   endtask

   initial begin
      step(2);
      t_reset();
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_regs();
      t_output();
      t_input();
      t_alt();
      t_level();
      t_edge();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule